// File: doc/BRIEF.md
# Rolling-Hash Dictionary Lookup Stage

This block is one element of a linear chain that tests query words against a dictionary. Each stage keeps a private table of presence bits, one per hashed address. Words arrive two characters at a time as a 16-bit pair. The stage folds every pair into an 18-bit running hash. That hash mixes in a per-stage key and is rotated after each pair. The last pair of a word is marked with an end-of-word flag.

In load mode, the final hash of each word marks its table address as present. In query mode, the stage reads the presence bit at the final address. It ORs that bit into the hit flag coming from the previous stage and sends the result onward as a one-cycle pulse. Character pairs, the end-of-word flag and the mode are re-registered toward the next stage, so the chain runs as a systolic pipeline. Because each stage has its own key and rotate amount, the same word lands at a different address in every table. A false hit therefore needs a collision in each stage that reported one.

Top module: `hash_lookup_stage`

## Requirements
- R1: After reset, every output is 0 and every table bit is clear, so a query of any word returns hit_o = hit_i.
- R2: The running hash starts at 0. Each accepted pair p updates it to h' = rotate-left-by-ROT over 18 bits of (h XOR p XOR HASH_KEY), with p and HASH_KEY zero-extended to 18 bits. The defaults are HASH_KEY = 16'hC8A3 and ROT = 7.
- R3: In load mode, the pair flagged with end-of-word sets the table bit addressed by the low ADDR_W bits of the final hash h'. The default ADDR_W is 6.
- R4: In query mode, the pair flagged with end-of-word is sampled at clock edge E0. hit_o then carries hit_i OR the table bit at the final address. It is valid for the single cycle after edge E0+1, and hit_i is sampled at edge E0+1.
- R5: hit_o is 0 in every cycle not produced by a query lookup, whatever hit_i does.
- R6: pair_o, pair_valid_o, eow_o and load_mode_o equal pair_i, pair_valid_i, eow_i and load_mode_i delayed by exactly one clock.
- R7: A cycle with clear_table_i high zeroes all table bits. This clear wins over a load write in the same cycle.
- R8: A cycle with pair_valid_i low leaves the running hash unchanged, so idle gaps inside a word do not change its address.
- R9: After an end-of-word pair, the running hash restarts from 0, so the next word hashes independently of the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clear_table_i | input | 1 | Zero all presence bits |
| pair_valid_i | input | 1 | pair_i carries a character pair |
| pair_i | input | 16 | Two characters of the current word |
| eow_i | input | 1 | Current pair is the last of the word |
| load_mode_i | input | 1 | 1 = load dictionary, 0 = query |
| hit_i | input | 1 | Hit flag from the previous stage |
| pair_valid_o | output | 1 | Forwarded pair_valid_i |
| pair_o | output | 16 | Forwarded pair_i |
| eow_o | output | 1 | Forwarded eow_i |
| load_mode_o | output | 1 | Forwarded load_mode_i |
| hit_o | output | 1 | Hit pulse to the next stage |

## Verification
The bench loads a set of one-pair and two-pair words. It then sweeps every 8-bit single-pair query value, with hit_i toggling, and compares hit_o against a table model built from the hash formula. A wrong key, rotate direction or address slice would show up as hits at the wrong addresses. The bench also splits a word with an idle cycle, to catch a hash that advances on invalid cycles. It queries the same word twice in a row, which exposes a hash that is not reset at end-of-word. A clear issued in the same cycle as a load write must leave that word absent, and a design that gives the write priority would report a false hit. hit_o is sampled in the one cycle it may be high and in the cycle before it, so an extra or missing register stage fails the check.

// File: rtl/hlk_pkg.sv
package hlk_pkg;
  localparam int HASH_W = 18;
  typedef logic [HASH_W-1:0] hash_t;

  function automatic hash_t rotl(input hash_t v, input int r);
    hash_t res;
    res = v;
    for (int k = 0; k < HASH_W; k++) begin
      if (k < r) res = {res[HASH_W-2:0], res[HASH_W-1]};
    end
    return res;
  endfunction
endpackage

// File: rtl/hash_step.sv
module hash_step
  import hlk_pkg::*;
#(
  parameter int                 PAIR_W   = 16,
  parameter logic [PAIR_W-1:0]  HASH_KEY = 16'hC8A3,
  parameter int                 ROT      = 7
) (
  input  hash_t             cur_i,
  input  logic [PAIR_W-1:0] pair_i,
  output hash_t             nxt_o
);
  localparam hash_t KEY_EXT = hash_t'(HASH_KEY);

  always_comb begin
    nxt_o = rotl(cur_i ^ hash_t'(pair_i) ^ KEY_EXT, ROT);
  end
endmodule

// File: rtl/presence_table.sv
module presence_table #(
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic              rd_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DEPTH-1:0] bits_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                            bits_q[g] <= 1'b0;
      else if (clr_i)                                         bits_q[g] <= 1'b0;
      else if (we_i && waddr_i == ADDR_W'(g))                 bits_q[g] <= 1'b1;
    end
  end

  assign rd_o = bits_q[raddr_i];

  // R7
  clear_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(clr_i) |-> bits_q == '0);
  // R3
  write_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(we_i) && !$past(clr_i)) |-> bits_q[$past(waddr_i)]);
endmodule

// File: rtl/fwd_pipe.sv
module fwd_pipe #(
  parameter int PAIR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [PAIR_W-1:0] pair_i,
  input  logic              eow_i,
  input  logic              mode_i,
  output logic              valid_o,
  output logic [PAIR_W-1:0] pair_o,
  output logic              eow_o,
  output logic              mode_o
);
  logic live_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      pair_o  <= '0;
      eow_o   <= 1'b0;
      mode_o  <= 1'b0;
      live_q  <= 1'b0;
    end else begin
      valid_o <= valid_i;
      pair_o  <= pair_i;
      eow_o   <= eow_i;
      mode_o  <= mode_i;
      live_q  <= 1'b1;
    end
  end

  // R6
  fwd_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q |-> (pair_o == $past(pair_i) && valid_o == $past(valid_i)
                && eow_o == $past(eow_i) && mode_o == $past(mode_i)));
endmodule

// File: rtl/hash_lookup_stage.sv
module hash_lookup_stage
  import hlk_pkg::*;
#(
  parameter int                PAIR_W   = 16,
  parameter logic [PAIR_W-1:0] HASH_KEY = 16'hC8A3,
  parameter int                ROT      = 7,
  parameter int                ADDR_W   = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_table_i,
  input  logic              pair_valid_i,
  input  logic [PAIR_W-1:0] pair_i,
  input  logic              eow_i,
  input  logic              load_mode_i,
  input  logic              hit_i,
  output logic              pair_valid_o,
  output logic [PAIR_W-1:0] pair_o,
  output logic              eow_o,
  output logic              load_mode_o,
  output logic              hit_o
);
  hash_t             hash_q, hash_nxt;
  logic              lookup_q;
  logic [ADDR_W-1:0] addr_q;
  logic              rd_bit;
  logic              word_end;

  assign word_end = pair_valid_i & eow_i;

  hash_step #(.PAIR_W(PAIR_W), .HASH_KEY(HASH_KEY), .ROT(ROT)) u_step (
    .cur_i (hash_q),
    .pair_i(pair_i),
    .nxt_o (hash_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hash_q   <= '0;
      lookup_q <= 1'b0;
      addr_q   <= '0;
      hit_o    <= 1'b0;
    end else begin
      if (pair_valid_i) hash_q <= eow_i ? '0 : hash_nxt;  // restart per word
      lookup_q <= word_end & ~load_mode_i;
      if (word_end) addr_q <= hash_nxt[ADDR_W-1:0];
      hit_o    <= lookup_q & (hit_i | rd_bit);
    end
  end

  presence_table #(.ADDR_W(ADDR_W)) u_table (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clear_table_i),
    .we_i   (word_end & load_mode_i),
    .waddr_i(hash_nxt[ADDR_W-1:0]),
    .raddr_i(addr_q),
    .rd_o   (rd_bit)
  );

  fwd_pipe #(.PAIR_W(PAIR_W)) u_fwd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(pair_valid_i),
    .pair_i (pair_i),
    .eow_i  (eow_i),
    .mode_i (load_mode_i),
    .valid_o(pair_valid_o),
    .pair_o (pair_o),
    .eow_o  (eow_o),
    .mode_o (load_mode_o)
  );

  // R5
  hit_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> $past(pair_valid_o & eow_o & ~load_mode_o));
  // R4
  hit_chain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(pair_valid_o & eow_o & ~load_mode_o) && $past(hit_i)) |-> hit_o);
  // R9
  hash_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(word_end) |-> hash_q == '0);
  // R8
  hash_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(pair_valid_i) |-> $stable(hash_q));
endmodule

// File: tb/sim_hash_lookup_stage.sv
`timescale 1ns/1ps
module sim_hash_lookup_stage;
  localparam int KEY = 'hC8A3;
  localparam int RT  = 7;
  localparam int AW  = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic clr = 1'b0, pv = 1'b0, eow = 1'b0, ld = 1'b0, hi = 1'b0;
  logic [15:0] pr = '0;
  logic pv_o, eow_o, ld_o, hit_o;
  logic [15:0] pr_o;

  int checks = 0, fails = 0;
  bit model [64];

  always #10 clk = ~clk;

  hash_lookup_stage u0 (
    .clk_i(clk), .rst_ni(rst_n), .clear_table_i(clr), .pair_valid_i(pv),
    .pair_i(pr), .eow_i(eow), .load_mode_i(ld), .hit_i(hi),
    .pair_valid_o(pv_o), .pair_o(pr_o), .eow_o(eow_o), .load_mode_o(ld_o),
    .hit_o(hit_o));

  function automatic int step_h(int h, int p);
    int v;
    v = (h ^ p ^ KEY) & 'h3FFFF;
    return ((v << RT) | (v >> (18 - RT))) & 'h3FFFF;
  endfunction

  function automatic int addr1(int p);
    return step_h(0, p) & ((1 << AW) - 1);
  endfunction

  function automatic int addr2(int p0, int p1);
    return step_h(step_h(0, p0), p1) & ((1 << AW) - 1);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(bit v, int p, bit e, bit l, bit h, bit c);
    @(negedge clk);
    pv = v; pr = 16'(p); eow = e; ld = l; hi = h; clr = c;
  endtask

  task automatic idle();
    drive(0, 0, 0, 0, 0, 0);
  endtask

  // single-pair query: checks forwarding, hit timing and value
  task automatic query1(int p, bit h, string req);
    drive(1, p, 1, 0, h, 0);
    drive(0, 0, 0, 0, h, 0);
    chk("R6 pair", int'(pr_o), p);
    chk("R6 eow", int'(eow_o), 1);
    chk("R5 early", int'(hit_o), 0);
    drive(0, 0, 0, 0, 0, 0);
    chk(req, int'(hit_o), int'(h | model[addr1(p)]));
  endtask

  task automatic query2(int p0, int p1, bit gap, string req);
    drive(1, p0, 0, 0, 0, 0);
    if (gap) drive(0, 'h5555, 0, 0, 1, 0);
    drive(1, p1, 1, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 0);
    chk("R5 early2", int'(hit_o), 0);
    drive(0, 0, 0, 0, 0, 0);
    chk(req, int'(hit_o), int'(model[addr2(p0, p1)]));
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    foreach (model[i]) model[i] = 0;
    repeat (3) @(negedge clk);
    chk("R1 hit", int'(hit_o), 0);
    chk("R1 fwd", int'({pv_o, eow_o, ld_o}), 0);
    chk("R1 pair", int'(pr_o), 0);
    rst_n = 1'b1;
    idle();
    // R1: empty table, hit follows hit_i
    query1('h7468, 0, "R1 empty");
    query1('h7468, 1, "R1 passthru");
    // R5: hit_i alone with no lookup
    drive(0, 0, 0, 0, 1, 0);
    drive(0, 0, 0, 0, 1, 0);
    chk("R5 nolookup", int'(hit_o), 0);
    drive(0, 0, 0, 1, 1, 0);
    drive(1, 'h1234, 1, 1, 1, 0);
    drive(0, 0, 0, 0, 1, 0);
    chk("R6 mode", int'(ld_o), 1);
    drive(0, 0, 0, 0, 0, 0);
    chk("R5 loadword", int'(hit_o), 0);
    model[addr1('h1234)] = 1;
    // R3: load single-pair words 0..39
    for (int k = 0; k < 40; k++) begin
      drive(1, k * 3 + 'h100, 1, 1, 0, 0);
      model[addr1(k * 3 + 'h100)] = 1;
    end
    // R3: load two-pair words
    drive(1, 'h6162, 0, 1, 0, 0);
    drive(1, 'h6364, 1, 1, 0, 0);
    model[addr2('h6162, 'h6364)] = 1;
    idle();
    // R2 R3 R4: sweep all 8-bit single-pair queries
    for (int p = 0; p < 256; p++) query1(p + 'h100, 1'(p & 1), "R4 sweep");
    // R2: multi-pair words
    query2('h6162, 'h6364, 0, "R2 two-pair");
    query2('h6364, 'h6162, 0, "R2 swapped");
    // R8: idle gap in a word
    query2('h6162, 'h6364, 1, "R8 gap");
    // R9: repeated word after end-of-word
    query2('h6162, 'h6364, 0, "R9 restart");
    query1('h1234, 0, "R9 after");
    // R7: clear wins over a same-cycle load
    drive(1, 'hBEEF, 1, 1, 0, 1);
    foreach (model[i]) model[i] = 0;
    idle();
    query1('hBEEF, 0, "R7 clear-wins");
    query1('h1234, 0, "R7 cleared");
    query2('h6162, 'h6364, 0, "R7 cleared2");
    drive(1, 'hBEEF, 1, 1, 0, 0);
    model[addr1('hBEEF)] = 1;
    idle();
    query1('hBEEF, 0, "R3 reload");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule